// File: doc/BRIEF.md
# Shared Event Interrupt Aggregator

This block collects 64 interrupt sources and presents them to the processor as one level-sensitive interrupt line. The low 21 sources are wired, active-high level inputs. The upper 43 are message-signalled events. A source in the message range becomes pending when a bus master writes that source's number to a single doorbell register. Every source owns one cause bit and one mask bit. The cause bits and mask bits are packed into two 32-bit cause registers and two 32-bit mask registers.

Software reaches the block through a simple 32-bit register port. A read returns data combinationally. A write takes effect on the clock edge where the write strobe is high. Software clears a pending source by writing a 1 to its cause bit. It enables or disables a source by writing its mask register. A mask bit of 1 means the source is disabled. The summary line `irq_out` is asserted whenever at least one pending source is enabled.

Top module: `evt_aggregator`

## Requirements
- R1: After reset, both cause registers read 0x0000_0000, both mask registers read 0xFFFF_FFFF, and `irq_out` is low.
- R2: The cause registers are at byte offsets 0x00 and 0x04, the mask registers at 0x20 and 0x24, and the doorbell at 0x30. Source n is held in register n/32 at bit n%32, so 0x00 and 0x20 cover sources 0..31. The doorbell and every unmapped offset read as zero.
- R3: A write to a mask register replaces all 32 mask bits with the write data. A mask bit of 1 disables its source and a mask bit of 0 enables it. Mask bits do not change without a mask write.
- R4: Writing a 1 to a cause bit clears that bit. Writing a 0 leaves that bit unchanged.
- R5: Sources 0..20 follow `wired_irq[n]`. While an input is high, its cause bit is set on every clock edge. A single-cycle pulse is latched. A clear written while the input is still high leaves the bit set.
- R6: A doorbell write whose data is a source number in 21..63 sets that source's cause bit on the write edge. The bit then stays set until software clears it. Writing a 1 to a message-range cause bit never sets it.
- R7: A doorbell write whose full 32-bit data lies outside 21..63 changes no cause bit. This includes 20, 64, and values with high bits set.
- R8: `irq_out` is registered. On each clock edge it takes the OR over all sources of (cause AND NOT mask), using the register state from before that edge.
- R9: The initialisation sequence writes all ones to both cause registers and both mask registers. Afterwards every cause bit is clear, except wired inputs that are still high. Every source is masked and `irq_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data (doorbell writes carry the source number) |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wired_irq | input | 21 | Level inputs for sources 0..20 |
| irq_out | output | 1 | Registered summary interrupt |

## Verification
The in-RTL properties check the per-bit rules on every cycle:
- a clear without a competing set drops the bit;
- a zero in the clear data keeps the bit;
- a set always lands;
- no bit rises on its own;
- mask registers load exactly the write data and otherwise hold;
- an in-range doorbell reaches the addressed bit, and an out-of-range one touches no message bit;
- the summary line trails the enabled-pending state by one edge.

Other behaviour only shows in the bench scenarios:
- each source lands at the correct register address and bit position;
- an acknowledge while a wired input is held high has no lasting effect;
- message events stay pending across idle cycles;
- the initialisation sequence leaves the block fully cleared and masked.

// File: rtl/evt_agg_pkg.sv
package evt_agg_pkg;

   // Byte distance between consecutive 32-bit registers of one group
   localparam int unsigned REG_STRIDE = 4;

   // True when v lies in the half-open range [lo, hi)
   function automatic logic in_range(logic [63:0] v, int unsigned lo, int unsigned hi);
      return (v >= 64'(lo)) && (v < 64'(hi));
   endfunction

endpackage

// File: rtl/evt_agg_regif.sv
module evt_agg_regif #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned NUM_BANKS  = 2,
   parameter int unsigned CAUSE_BASE = 'h00,
   parameter int unsigned MASK_BASE  = 'h20,
   parameter int unsigned DB_OFS     = 'h30
) (
   input  logic                        bus_wr,
   input  logic [ADDR_W-1:0]           bus_addr,
   input  logic [NUM_BANKS*DATA_W-1:0] cause_all,
   input  logic [NUM_BANKS*DATA_W-1:0] mask_all,
   output logic [NUM_BANKS-1:0]        cause_wr,
   output logic [NUM_BANKS-1:0]        mask_wr,
   output logic                        db_wr,
   output logic [DATA_W-1:0]           bus_rdata
);
   import evt_agg_pkg::*;

   localparam int unsigned WIN_BYTES = NUM_BANKS * REG_STRIDE;
   localparam logic [ADDR_W-1:0] DB_ADDR = ADDR_W'(DB_OFS);

   // elaboration checks: windows in order, no overlap, inside address space
   if (CAUSE_BASE + WIN_BYTES > MASK_BASE) begin : g_chk_cause_win
      $error("cause window overlaps mask window");
   end
   if (MASK_BASE + WIN_BYTES > DB_OFS) begin : g_chk_mask_win
      $error("mask window overlaps doorbell");
   end
   if (DB_OFS >= (1 << ADDR_W)) begin : g_chk_db_addr
      $error("doorbell offset does not fit ADDR_W");
   end

   logic [NUM_BANKS-1:0] hit_cause;
   logic [NUM_BANKS-1:0] hit_mask;

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_dec
      localparam logic [ADDR_W-1:0] C_ADDR = ADDR_W'(CAUSE_BASE + b * REG_STRIDE);
      localparam logic [ADDR_W-1:0] M_ADDR = ADDR_W'(MASK_BASE + b * REG_STRIDE);
      assign hit_cause[b] = (bus_addr == C_ADDR);
      assign hit_mask[b]  = (bus_addr == M_ADDR);
      assign cause_wr[b]  = bus_wr & hit_cause[b];
      assign mask_wr[b]   = bus_wr & hit_mask[b];
   end

   assign db_wr = bus_wr & (bus_addr == DB_ADDR);

   // read mux: doorbell and unmapped offsets return zero
   always_comb begin
      bus_rdata = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (hit_cause[b]) bus_rdata = cause_all[b*DATA_W +: DATA_W];
         if (hit_mask[b])  bus_rdata = mask_all[b*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/evt_agg_db_decode.sv
module evt_agg_db_decode #(
   parameter int unsigned NUM_SRC   = 64,
   parameter int unsigned NUM_WIRED = 21,
   parameter int unsigned DATA_W    = 32
) (
   input  logic                         db_wr,
   input  logic [DATA_W-1:0]            db_data,
   output logic [NUM_SRC-NUM_WIRED-1:0] db_set
);
   import evt_agg_pkg::*;

   localparam int unsigned NUM_MSG = NUM_SRC - NUM_WIRED;

   if (DATA_W > 64) begin : g_chk_width
      $error("doorbell data wider than the range comparator");
   end

   logic in_rng;
   assign in_rng = in_range(64'(db_data), NUM_WIRED, NUM_SRC);

   // one comparator per message source; the full data word must match
   for (genvar m = 0; m < NUM_MSG; m++) begin : g_cmp
      localparam logic [DATA_W-1:0] SRC_NUM = DATA_W'(NUM_WIRED + m);
      assign db_set[m] = db_wr & in_rng & (db_data == SRC_NUM);
   end

endmodule

// File: rtl/evt_agg_bank.sv
module evt_agg_bank #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cause_wr,
   input  logic              mask_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] set_in,
   output logic [DATA_W-1:0] cause_q,
   output logic [DATA_W-1:0] mask_q,
   output logic [DATA_W-1:0] pend
);

   logic [DATA_W-1:0] clr_vec;
   assign clr_vec = cause_wr ? wdata : '0;

   // cause: write-one-to-clear, a set in the same cycle wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cause_q <= '0;
      else        cause_q <= (cause_q & ~clr_vec) | set_in;
   end

   // mask: 1 disables, reset leaves every source disabled
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '1;
      else if (mask_wr) mask_q <= wdata;
   end

   assign pend = cause_q & ~mask_q;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit_chk
      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (cause_wr && wdata[i] && !set_in[i]) |=> !cause_q[i]); // R4
      AST_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
         (cause_wr && !wdata[i] && cause_q[i]) |=> cause_q[i]); // R4
      AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
         set_in[i] |=> cause_q[i]); // R5
      AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_in[i] && !cause_q[i]) |=> !cause_q[i]); // R6
   end

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr |=> (mask_q == $past(wdata))); // R3
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr |=> $stable(mask_q)); // R3

endmodule

// File: rtl/evt_agg_summary.sv
module evt_agg_summary #(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned OUT_REG = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_all,
   output logic               irq
);

   if (OUT_REG > 1) begin : g_chk_opt
      $error("OUT_REG must be 0 or 1");
   end

   if (OUT_REG == 1) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |pend_all;
      end
   end else begin : g_comb
      // clk/rst_n unused in this variant
      logic unused_ok;
      assign unused_ok = clk ^ rst_n;
      assign irq = |pend_all;
   end

endmodule

// File: rtl/evt_aggregator.sv
module evt_aggregator #(
   parameter int unsigned NUM_SRC    = 64,
   parameter int unsigned NUM_WIRED  = 21,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned CAUSE_BASE = 'h00,
   parameter int unsigned MASK_BASE  = 'h20,
   parameter int unsigned DB_OFS     = 'h30,
   parameter int unsigned OUT_REG    = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   input  logic [NUM_WIRED-1:0] wired_irq,
   output logic                 irq_out
);
   import evt_agg_pkg::*;

   localparam int unsigned NUM_BANKS = NUM_SRC / DATA_W;
   localparam int unsigned NUM_MSG   = NUM_SRC - NUM_WIRED;
   localparam int unsigned IDX_W     = $clog2(NUM_SRC);
   localparam logic [NUM_SRC-1:0] MSG_BITS = {{NUM_MSG{1'b1}}, {NUM_WIRED{1'b0}}};

   if (NUM_SRC % DATA_W != 0) begin : g_chk_div
      $error("NUM_SRC must be a multiple of DATA_W");
   end
   if (NUM_WIRED < 1 || NUM_WIRED >= NUM_SRC) begin : g_chk_split
      $error("NUM_WIRED must leave at least one source on each side");
   end

   logic [NUM_BANKS-1:0]        cause_wr;
   logic [NUM_BANKS-1:0]        mask_wr;
   logic                        db_wr;
   logic [NUM_MSG-1:0]          db_set;
   logic [NUM_SRC-1:0]          src_set;
   logic [NUM_SRC-1:0]          cause_all;
   logic [NUM_SRC-1:0]          mask_all;
   logic [NUM_SRC-1:0]          pend_all;

   evt_agg_regif #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .NUM_BANKS (NUM_BANKS),
      .CAUSE_BASE(CAUSE_BASE),
      .MASK_BASE (MASK_BASE),
      .DB_OFS    (DB_OFS)
   ) regif_i (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .cause_all(cause_all),
      .mask_all (mask_all),
      .cause_wr (cause_wr),
      .mask_wr  (mask_wr),
      .db_wr    (db_wr),
      .bus_rdata(bus_rdata)
   );

   evt_agg_db_decode #(
      .NUM_SRC  (NUM_SRC),
      .NUM_WIRED(NUM_WIRED),
      .DATA_W   (DATA_W)
   ) db_dec_i (
      .db_wr  (db_wr),
      .db_data(bus_wdata),
      .db_set (db_set)
   );

   // fixed split of the index space: wired sources low, message sources high
   assign src_set = {db_set, wired_irq};

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      evt_agg_bank #(
         .DATA_W(DATA_W)
      ) bank_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .cause_wr(cause_wr[b]),
         .mask_wr (mask_wr[b]),
         .wdata   (bus_wdata),
         .set_in  (src_set[b*DATA_W +: DATA_W]),
         .cause_q (cause_all[b*DATA_W +: DATA_W]),
         .mask_q  (mask_all[b*DATA_W +: DATA_W]),
         .pend    (pend_all[b*DATA_W +: DATA_W])
      );
   end

   evt_agg_summary #(
      .NUM_SRC(NUM_SRC),
      .OUT_REG(OUT_REG)
   ) summary_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pend_all(pend_all),
      .irq     (irq_out)
   );

   logic db_in_rng;
   assign db_in_rng = in_range(64'(bus_wdata), NUM_WIRED, NUM_SRC);

   AST_DB_SETS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      (db_wr && db_in_rng) |=> cause_all[$past(bus_wdata[IDX_W-1:0])]); // R6
   AST_DB_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (db_wr && !db_in_rng) |=> (((cause_all & ~$past(cause_all)) & MSG_BITS) == '0)); // R7
   AST_BUS_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cause_wr, mask_wr, db_wr})); // R2

   if (OUT_REG == 1) begin : g_irq_chk
      AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq_out == $past(|(cause_all & ~mask_all)))); // R8
   end

endmodule

// File: tb/evt_aggregator_tb_top.sv
module evt_aggregator_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic [20:0] wired_irq = '0;
   logic        irq_out;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   // reference state
   bit [63:0] m_cause;
   bit [63:0] m_mask;
   bit        m_irq;

   always #10 clk = ~clk;  // 50 MHz

   evt_aggregator dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .wired_irq(wired_irq),
      .irq_out  (irq_out)
   );

   // behavioural model, advanced on every rising edge
   always @(posedge clk) begin
      bit [63:0] set_v;
      bit [63:0] clr_v;
      if (!rst_n) begin
         m_cause = '0;
         m_mask  = '1;
         m_irq   = 1'b0;
      end else begin
         m_irq = (m_cause & ~m_mask) != 0;
         set_v = {43'b0, wired_irq};
         clr_v = '0;
         if (bus_wr) begin
            case (bus_addr)
               8'h00: clr_v[31:0]  = bus_wdata;
               8'h04: clr_v[63:32] = bus_wdata;
               8'h20: m_mask[31:0]  = bus_wdata;
               8'h24: m_mask[63:32] = bus_wdata;
               8'h30: if (bus_wdata >= 21 && bus_wdata <= 63) set_v[bus_wdata[5:0]] = 1'b1;
               default: ;
            endcase
         end
         m_cause = (m_cause & ~clr_v) | set_v;
      end
   end

   // summary line compared on every falling edge
   always @(negedge clk) begin
      if (!done) begin
         vectors++;
         if (irq_out !== m_irq) begin
            errors++;
            $display("FAIL R8 irq_out at %0t: actual %0b expected %0b", $time, irq_out, m_irq);
         end
      end
   end

   function automatic bit [31:0] model_rd(bit [7:0] a);
      case (a)
         8'h00:   return m_cause[31:0];
         8'h04:   return m_cause[63:32];
         8'h20:   return m_mask[31:0];
         8'h24:   return m_mask[63:32];
         default: return 32'h0;
      endcase
   endfunction

   task automatic bus_write(input bit [7:0] a, input bit [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = 32'h0;
   endtask

   // read, compare against both the model and a literal expectation
   task automatic chk_rd(input bit [7:0] a, input bit [31:0] exp, input string tag);
      bus_addr = a;
      #1;
      vectors++;
      if (bus_rdata !== exp || bus_rdata !== model_rd(a)) begin
         errors++;
         $display("FAIL %s read 0x%02h: actual 0x%08h expected 0x%08h (model 0x%08h)",
                  tag, a, bus_rdata, exp, model_rd(a));
      end
      @(negedge clk);
   endtask

   task automatic chk_irq(input bit exp, input string tag);
      #1;
      vectors++;
      if (irq_out !== exp) begin
         errors++;
         $display("FAIL %s irq_out: actual %0b expected %0b", tag, irq_out, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk_rd(8'h00, 32'h0000_0000, "R1");
      chk_rd(8'h04, 32'h0000_0000, "R1");
      chk_rd(8'h20, 32'hFFFF_FFFF, "R1");
      chk_rd(8'h24, 32'hFFFF_FFFF, "R1");
      chk_irq(1'b0, "R1");
      // R2 doorbell and unmapped offsets read zero
      chk_rd(8'h30, 32'h0, "R2");
      chk_rd(8'h10, 32'h0, "R2");

      // R3 enable everything
      bus_write(8'h20, 32'h0);
      bus_write(8'h24, 32'h0);
      chk_rd(8'h20, 32'h0, "R3");
      chk_rd(8'h24, 32'h0, "R3");

      // R5 wired level, ack while held high
      wired_irq[3] = 1'b1;
      idle(2);
      chk_rd(8'h00, 32'h0000_0008, "R5");
      chk_irq(1'b1, "R8");
      bus_write(8'h00, 32'h0000_0008);
      chk_rd(8'h00, 32'h0000_0008, "R5");
      wired_irq[3] = 1'b0;
      idle(1);
      bus_write(8'h00, 32'h0000_0008);
      chk_rd(8'h00, 32'h0, "R4");
      idle(1);
      chk_irq(1'b0, "R8");

      // R5 single-cycle pulse on source 20 is latched
      wired_irq[20] = 1'b1;
      idle(1);
      wired_irq[20] = 1'b0;
      idle(1);
      chk_rd(8'h00, 32'h0010_0000, "R5");
      bus_write(8'h00, 32'h0010_0000);
      chk_rd(8'h00, 32'h0, "R4");

      // R6 doorbell events, placement per R2
      bus_write(8'h30, 32'd21);
      chk_rd(8'h00, 32'h0020_0000, "R6");
      idle(3);
      chk_rd(8'h00, 32'h0020_0000, "R6");
      bus_write(8'h30, 32'd63);
      bus_write(8'h30, 32'd40);
      chk_rd(8'h04, 32'h8000_0100, "R6");

      // R4 clear one bit, zeros keep
      bus_write(8'h04, 32'h0000_0100);
      chk_rd(8'h04, 32'h8000_0000, "R4");
      bus_write(8'h04, 32'h0000_0000);
      chk_rd(8'h04, 32'h8000_0000, "R4");
      // R6 writing 1 to a clear message bit does not set it
      bus_write(8'h04, 32'h0000_0001);
      chk_rd(8'h04, 32'h8000_0000, "R6");

      // R7 out-of-range doorbells ignored
      bus_write(8'h30, 32'd20);
      bus_write(8'h30, 32'd64);
      bus_write(8'h30, 32'hFFFF_FFF5);
      bus_write(8'h30, 32'h0000_0115);
      chk_rd(8'h00, 32'h0020_0000, "R7");
      chk_rd(8'h04, 32'h8000_0000, "R7");

      // R3 masking gates the summary
      bus_write(8'h20, 32'hFFFF_FFFF);
      idle(1);
      chk_irq(1'b1, "R3");
      bus_write(8'h24, 32'h8000_0000);
      idle(1);
      chk_irq(1'b0, "R3");
      chk_rd(8'h24, 32'h8000_0000, "R3");
      bus_write(8'h20, 32'h0);
      idle(1);
      chk_irq(1'b1, "R3");

      // R9 initialisation with a wired input held high
      wired_irq[5] = 1'b1;
      bus_write(8'h00, 32'hFFFF_FFFF);
      bus_write(8'h04, 32'hFFFF_FFFF);
      bus_write(8'h20, 32'hFFFF_FFFF);
      bus_write(8'h24, 32'hFFFF_FFFF);
      chk_rd(8'h00, 32'h0000_0020, "R9");
      chk_rd(8'h04, 32'h0, "R9");
      chk_rd(8'h20, 32'hFFFF_FFFF, "R9");
      chk_rd(8'h24, 32'hFFFF_FFFF, "R9");
      chk_irq(1'b0, "R9");
      wired_irq[5] = 1'b0;
      idle(1);
      bus_write(8'h00, 32'hFFFF_FFFF);
      chk_rd(8'h00, 32'h0, "R9");
      idle(2);
      chk_irq(1'b0, "R9");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule